// File: doc/BRIEF.md
# Strap-Pin Clock Fan-Out Configuration Controller

This block decides how a four-output clock fan-out is configured and produces the four gated output clocks from a reference clock. Each setting has a strap pin and a register bit that software has written. The pin always has priority. A register bit can change a setting only where the level of the pin allows it. The settings are which outputs run, whether the outputs carry the reference clock itself (buffer mode) or a divided copy of it (divider mode), and the division ratio.

The strap pins are asynchronous and pass through a two-flop synchronizer in the reference domain before they are decoded. The register inputs are taken to be static, or to be written in the reference domain. A new mode or ratio is applied only when the divider counter wraps. An output enable is applied only while the selected source clock is low. As a result, no output shows a shortened pulse.

Three status outputs report the mode and ratio in use, and a sticky flag reports an illegal register ratio that was actually selected.

Top module: `clk_strap_ctrl`

## Requirements
- R1: Enable pin `en_pin0` controls output 0, `en_pin1` controls output 1, and `en_pin23` controls both outputs 2 and 3.
- R2: While an enable pin is low, its outputs stay low whatever the value of `reg_ch_off`.
- R3: While an enable pin is high, its outputs toggle unless the matching `reg_ch_off` bit is 1, which holds that output low.
- R4: With `mode_pin` low, the block is in buffer mode (`mode_div`=0, each enabled output follows `clk_ref`) unless `reg_div_mode` is 1, which selects divider mode.
- R5: With `mode_pin` high, the block is in divider mode (`mode_div`=1) whatever the value of `reg_div_mode`.
- R6: `ratio_pin` code 2'b01 gives divide-by-2, code 2'b10 gives divide-by-3 and code 2'b11 gives divide-by-4. `ratio_val` reports the ratio as a binary number, and in divider mode an enabled output has one rising edge per that many reference cycles.
- R7: `ratio_pin` code 2'b00 takes the ratio from `reg_ratio` when that field is 2, 3 or 4. Any other value gives ratio 2. If that happens while the block is in divider mode, `cfg_err` is set and stays 1 until reset. An illegal value that goes unused in buffer mode leaves `cfg_err` at 0.
- R8: Every output that is running is high for exactly half of the time, for every ratio including 3.
- R9: The mode and the ratio change only on the reference edge where the divider counter wraps, which is also the edge where a new output pulse starts.
- R10: An output enable changes only while the selected source clock is low, so every output pulse has its full width.
- R11: While `rst_n` is low, all outputs are low, `mode_div` is 0, `ratio_val` is 2 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, the source of every output |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin0 | input | 1 | Enable strap for output 0 |
| en_pin1 | input | 1 | Enable strap for output 1 |
| en_pin23 | input | 1 | Shared enable strap for outputs 2 and 3 |
| mode_pin | input | 1 | Mode strap: 0 selects buffer mode (register may override), 1 forces divider mode |
| ratio_pin | input | 2 | Ratio strap code: 00 uses the register, 01 gives /2, 10 gives /3, 11 gives /4 |
| reg_ch_off | input | 4 | Register bits, one per output, that turn off an output whose pin enables it |
| reg_div_mode | input | 1 | Register bit that selects divider mode while `mode_pin` is low |
| reg_ratio | input | 3 | Register ratio, used when `ratio_pin` is 00 |
| clk_out | output | 4 | Gated output clocks |
| mode_div | output | 1 | Mode in use: 1 for divider mode |
| ratio_val | output | 3 | Ratio in use |
| cfg_err | output | 1 | Sticky flag for an illegal register ratio that was selected |

## Verification
The assertions assume that `clk_ref` runs without interruption and that the register inputs change only between reference edges. The bench therefore drives every input 2 ns after an edge. The window properties also assume that the counter starts from its reset value, so none of them is enabled until `rst_n` is high. The strap pins are changed at arbitrary points relative to the divider phase. The bench then waits long enough for the synchronizer and for the next counter wrap before it reads any status. The ratio sweep starts with legal register values so that the sticky flag is checked while still clear before it is first set.

// File: rtl/clk_strap_ctrl.sv
module clk_strap_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       en_pin0,
  input  logic       en_pin1,
  input  logic       en_pin23,
  input  logic       mode_pin,
  input  logic [1:0] ratio_pin,
  input  logic [3:0] reg_ch_off,
  input  logic       reg_div_mode,
  input  logic [2:0] reg_ratio,
  output logic [3:0] clk_out,
  output logic       mode_div,
  output logic [2:0] ratio_val,
  output logic       cfg_err
);
  localparam int PW = 6;

  logic [SYNC_STAGES-1:0][PW-1:0] sq;
  logic [PW-1:0] ps;
  logic [2:0] cnt, act_ratio, want_ratio;
  logic act_div, neg_q;
  logic [3:0] en_q;

  assign ps = sq[SYNC_STAGES-1];

  wire [3:0] pin_en   = {ps[2], ps[2], ps[1], ps[0]};
  wire       want_div = ps[3] | reg_div_mode;
  wire [1:0] rcode    = ps[5:4];
  wire       reg_ok   = (reg_ratio >= 3'd2) && (reg_ratio <= 3'd4);
  wire       bad_use  = want_div && (rcode == 2'b00) && !reg_ok;

  always_comb begin
    case (rcode)
      2'b01:   want_ratio = 3'd2;
      2'b10:   want_ratio = 3'd3;
      2'b11:   want_ratio = 3'd4;
      default: want_ratio = reg_ok ? reg_ratio : 3'd2;
    endcase
  end

  wire tc      = (cnt == act_ratio - 3'd1);
  wire pos_hi  = (cnt < (act_ratio >> 1));
  wire div_clk = pos_hi | neg_q;
  wire src     = act_div ? div_clk : clk_ref;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sq        <= '0;
      cnt       <= '0;
      act_ratio <= 3'd2;
      act_div   <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      sq      <= {sq[SYNC_STAGES-2:0], {ratio_pin, mode_pin, en_pin23, en_pin1, en_pin0}};
      cfg_err <= cfg_err | bad_use;
      if (tc) begin
        cnt       <= '0;
        act_ratio <= want_ratio;
        act_div   <= want_div;
      end else begin
        cnt <= cnt + 3'd1;
      end
    end
  end

  always_ff @(negedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      en_q  <= '0;
    end else begin
      neg_q <= pos_hi & act_ratio[0];
      if (!act_div || !pos_hi) en_q <= pin_en & ~reg_ch_off;
    end
  end

  assign clk_out   = {4{src}} & en_q;
  assign mode_div  = act_div;
  assign ratio_val = act_ratio;
endmodule

module clk_strap_ctrl_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [2:0] cnt,
  input logic [2:0] act_ratio,
  input logic       act_div,
  input logic       pos_hi,
  input logic [3:0] en_q,
  input logic       cfg_err
);
  assert_ratio_legal_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act_ratio >= 3'd2) && (act_ratio <= 3'd4));

  assert_err_sticky_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err);

  assert_cnt_bound_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt < act_ratio);

  assert_switch_at_wrap_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act_ratio != $past(act_ratio) || act_div != $past(act_div)) |-> cnt == 3'd0);

  assert_gate_while_low_R10: assert property (@(negedge clk_ref) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> ($past(!act_div) || $past(!pos_hi)));
endmodule

bind clk_strap_ctrl clk_strap_ctrl_chk i_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .cnt(cnt), .act_ratio(act_ratio),
  .act_div(act_div), .pos_hi(pos_hi), .en_q(en_q), .cfg_err(cfg_err)
);

// File: tb/test_clk_strap_ctrl.sv
module test_clk_strap_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_pin0 = 1'b0, en_pin1 = 1'b0, en_pin23 = 1'b0, mode_pin = 1'b0, reg_div_mode = 1'b0;
  logic [1:0] ratio_pin = 2'b01;
  logic [3:0] reg_ch_off = '0;
  logic [2:0] reg_ratio = 3'd2;
  logic [3:0] clk_out;
  logic mode_div, cfg_err;
  logic [2:0] ratio_val;

  int nchk = 0, nerr = 0;
  int hi [4];
  int rs [4];
  logic [3:0] prev;
  bit done = 0;

  always #5 clk = ~clk;

  clk_strap_ctrl i_clk_strap_ctrl (
    .clk_ref(clk), .rst_n(rst_n), .en_pin0(en_pin0), .en_pin1(en_pin1), .en_pin23(en_pin23),
    .mode_pin(mode_pin), .ratio_pin(ratio_pin), .reg_ch_off(reg_ch_off),
    .reg_div_mode(reg_div_mode), .reg_ratio(reg_ratio), .clk_out(clk_out),
    .mode_div(mode_div), .ratio_val(ratio_val), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  // samples at posedge+2 and negedge+2 over n cycles
  task automatic measure(input int n);
    for (int c = 0; c < 4; c++) begin hi[c] = 0; rs[c] = 0; end
    @(negedge clk); #2 prev = clk_out;
    for (int i = 0; i < 2 * n; i++) begin
      if (i % 2 == 0) begin @(posedge clk); #2; end
      else begin @(negedge clk); #2; end
      for (int c = 0; c < 4; c++) begin
        if (clk_out[c]) hi[c]++;
        if (clk_out[c] && !prev[c]) rs[c]++;
      end
      prev = clk_out;
    end
  endtask

  // R9: at every posedge where the status changes, a new pulse starts on output 0
  task automatic watch(input int n);
    logic [3:0] st, st0;
    @(posedge clk); #2 st0 = {mode_div, ratio_val};
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2 st = {mode_div, ratio_val};
      if (st != st0) chk(clk_out[0] == 1'b1, "R9 pulse start at change", int'(clk_out[0]), 1);
      st0 = st;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit err_exp;
    // R11 reset state
    #22;
    chk(clk_out == 4'b0, "R11 outputs", int'(clk_out), 0);
    chk(mode_div == 1'b0, "R11 mode", int'(mode_div), 0);
    chk(ratio_val == 3'd2, "R11 ratio", int'(ratio_val), 2);
    chk(cfg_err == 1'b0, "R11 err", int'(cfg_err), 0);
    @(negedge clk); rst_n = 1'b1;

    // R7: illegal register ratio unused in buffer mode leaves the flag clear
    en_pin0 = 1; en_pin1 = 1; en_pin23 = 1;
    ratio_pin = 2'b00; reg_ratio = 3'd7;
    wait_cyc(20);
    chk(cfg_err == 1'b0, "R7 unused illegal ratio", int'(cfg_err), 0);
    chk(ratio_val == 3'd2, "R7 fallback ratio", int'(ratio_val), 2);

    // Mode/ratio sweep
    err_exp = 0;
    for (int k = 0; k < 8; k++) begin
      for (int mp = 0; mp < 2; mp++) begin
        for (int rd = 0; rd < 2; rd++) begin
          for (int rp = 0; rp < 4; rp++) begin
            int rr, er, ed;
            bit dv, okr;
            rr = (k + 2) % 8;
            mode_pin = mp[0]; reg_div_mode = rd[0]; ratio_pin = rp[1:0]; reg_ratio = rr[2:0];
            dv = mp[0] | rd[0];
            okr = (rr >= 2) && (rr <= 4);
            er = (rp == 1) ? 2 : (rp == 2) ? 3 : (rp == 3) ? 4 : (okr ? rr : 2);
            if (dv && rp == 0 && !okr) err_exp = 1;
            wait_cyc(16);
            chk(mode_div == dv, mp ? "R5 forced divider" : "R4 buffer/override", int'(mode_div), int'(dv));
            chk(int'(ratio_val) == er, rp ? "R6 pin ratio" : "R7 register ratio", int'(ratio_val), er);
            chk(cfg_err == err_exp, "R7 sticky flag", int'(cfg_err), int'(err_exp));
            measure(12);
            ed = dv ? 12 / er : 12;
            chk(rs[0] == ed, dv ? "R6 edge count" : "R4 follows reference", rs[0], ed);
            chk(hi[0] == 12, "R8 duty", hi[0], 12);
          end
        end
      end
    end

    // R1/R2/R3 enable sweep in buffer mode
    mode_pin = 0; reg_div_mode = 0; ratio_pin = 2'b01;
    for (int e = 0; e < 8; e++) begin
      for (int o = 0; o < 16; o++) begin
        logic [3:0] pe;
        en_pin0 = e[0]; en_pin1 = e[1]; en_pin23 = e[2]; reg_ch_off = o[3:0];
        pe = {e[2], e[2], e[1], e[0]};
        wait_cyc(8);
        measure(4);
        for (int c = 0; c < 4; c++) begin
          int eo;
          eo = (pe[c] && !o[c]) ? 1 : 0;
          if (o == 0) chk((hi[c] > 0) == (eo == 1), "R1 pin mapping", int'(hi[c] > 0), eo);
          else if (!pe[c]) chk(hi[c] == 0, "R2 pin low forces off", hi[c], 0);
          else chk((hi[c] > 0) == (eo == 1), "R3 register off", int'(hi[c] > 0), eo);
        end
      end
    end
    reg_ch_off = '0; en_pin0 = 1; en_pin1 = 1; en_pin23 = 1;

    // R9 transitions
    mode_pin = 1; ratio_pin = 2'b01; watch(30);
    ratio_pin = 2'b11; watch(30);
    ratio_pin = 2'b10; watch(30);
    ratio_pin = 2'b00; reg_ratio = 3'd4; watch(30);
    mode_pin = 0; reg_div_mode = 0; watch(30);
    reg_div_mode = 1; watch(30);
    reg_div_mode = 0; ratio_pin = 2'b10; watch(30);
    reg_div_mode = 1; watch(30);

    // R10 enable toggling in divide-by-4: every pulse is full width
    mode_pin = 1; ratio_pin = 2'b11;
    wait_cyc(16);
    begin
      int run;
      bit seen0;
      run = 0; seen0 = 0;
      for (int i = 0; i < 600; i++) begin
        if (i % 2 == 0) begin @(posedge clk); #2; end
        else begin @(negedge clk); #2; end
        if (clk_out[0]) run++;
        else begin
          if (seen0 && run > 0) chk(run == 4, "R10 full pulse", run, 4);
          run = 0; seen0 = 1;
        end
        if ((i * 7) % 11 == 3) reg_ch_off[0] = ~reg_ch_off[0];
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule